// File: doc/BRIEF.md
# Sensor sample-tick and interrupt controller

This block produces the data-ready timing and the interrupt pin of a sensor's register interface. A prescaler turns the system clock into an internal base rate, 8 kHz or 1 kHz, chosen by a 3-bit filter bandwidth code. An 8-bit divider then stretches that base rate into sample ticks. Each sample tick sets a raw-data-ready status flag. A rising edge on the `pll_locked` input sets a clock-ready flag.

A configuration byte decides which of these two events reach the interrupt pin. It also sets the pin's polarity and its drive type (push-pull, or open drain modelled with an output enable). It selects whether the interrupt is latched or is a fixed-width pulse, and whether the latch is cleared by any register read or only by a read of the status register.

A plain single-cycle read/write port takes the place of the serial bus. There is no data stream at the block's edge, so every pin is a plain control or status signal with no handshake and no back-pressure.

Register addresses:
- 0: divider, 8 bits.
- 1: filter code, 3 bits.
- 2: interrupt configuration, 8 bits.
- 3: status, read-only.

Read data is combinational and is valid in the cycle in which `reg_rd` is high. A write takes effect at the next clock edge.

Top module: `sens_tick_irq`

## Requirements
- R1: Filter code 0 selects a base tick every FAST_CYC clock cycles. Codes 1 to 7 select a base tick every SLOW_CYC cycles (8 kHz and 1 kHz at the default clock).
- R2: Sample ticks repeat every base*(D+1) cycles, where D is the divider value (0 to 255). The raw-ready flag becomes readable base*(D+1) cycles after the edge of the last divider or filter write.
- R3: A write to the divider (address 0) or to the filter code (address 1) restarts both the prescaler and the divider count at that write's clock edge.
- R4: All registers reset to 0. The divider and the filter code read back what was written. In the configuration byte, bits 3 and 1 always read as 0.
- R5: Status bit 0 is raw-ready: it sets on each sample tick. Status bit 2 is clock-ready: it sets on a rising edge of `pll_locked`. A status read returns the flags as they were before the read and clears them at the end of that cycle. A new set in the same cycle wins over the clear.
- R6: Configuration bit 0 lets sample ticks raise the interrupt. Configuration bit 2 lets clock-ready events raise it. With an enable bit at 0, its event leaves the interrupt inactive while the status flag still sets.
- R7: With configuration bit 5 = 1 the interrupt latches until cleared. When bit 4 = 1 a read of any address clears it. When bit 4 = 0 only a status read clears it. The clear takes effect in the cycle after the read.
- R8: With configuration bit 5 = 0 each enabled event gives an active interrupt for exactly PULSE_CYC cycles, starting the cycle after the event. A new event restarts the pulse.
- R9: Configuration bit 7 selects polarity. The pin value is the active state when bit 7 = 0, and its inverse when bit 7 = 1.
- R10: Configuration bit 6 = 1 makes `int_oe` follow the active state (open drain). Bit 6 = 0 holds `int_oe` at 1 (push-pull).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, zero when not reading |
| pll_locked | input | 1 | Clock-source lock indication; its rising edge sets clock-ready |
| int_pin | output | 1 | Interrupt pin level |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
Read data is due in the same cycle as the read strobe. Flags and interrupt state change at the edge that ends the cycle of their cause, and are seen one cycle later. The first raw-ready sighting after a restart is therefore base*(D+1) cycles past the restart edge. Successive sightings are spaced by the same amount, and a read clear shows on the pin in the following cycle.

The bench drives every input at the falling edge and samples 1 ns later, keeping its own cycle counter. It compares sighting cycles and pulse lengths against the arithmetic from base, divider and PULSE_CYC. It sweeps filter codes and divider values up to 255.

// File: rtl/sti_pkg.sv
package sti_pkg;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DIV  = 2'd0;
  localparam logic [ADDR_W-1:0] A_FILT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  // writable configuration bits; positions 3 and 1 stay zero
  localparam logic [7:0] CFG_MASK = 8'hF5;

  typedef struct packed {
    logic act_low;     // 7
    logic open_drain;  // 6
    logic latch;       // 5
    logic any_rd_clr;  // 4
    logic rsv3;        // 3
    logic clk_en;      // 2
    logic rsv1;        // 1
    logic raw_en;      // 0
  } irq_cfg_t;
endpackage

// File: rtl/sti_regs.sv
module sti_regs
  import sti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [7:0]        status,
  output logic [7:0]        reg_rdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [CODE_W-1:0] code_q,
  output irq_cfg_t          cfg_q,
  output logic              restart,
  output logic              status_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      code_q <= '0;
      cfg_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DIV:   div_q  <= reg_wdata[DIV_W-1:0];
        A_FILT:  code_q <= reg_wdata[CODE_W-1:0];
        A_CFG:   cfg_q  <= irq_cfg_t'(reg_wdata & CFG_MASK);
        default: ;
      endcase
    end
  end

  assign restart   = reg_wr && (reg_addr == A_DIV || reg_addr == A_FILT);
  assign status_rd = reg_rd && (reg_addr == A_STAT);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_DIV:   reg_rdata = 8'(div_q);
        A_FILT:  reg_rdata = 8'(code_q);
        A_CFG:   reg_rdata = cfg_q;
        default: reg_rdata = status;
      endcase
    end
  end

  // R4
  cfg_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CFG) |-> (reg_rdata[3] == 1'b0 && reg_rdata[1] == 1'b0));
endmodule

// File: rtl/sti_tick.sv
module sti_tick
  import sti_pkg::*;
#(
  parameter int unsigned FAST_CYC = 31250,
  parameter int unsigned SLOW_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  input  logic [DIV_W-1:0]  div,
  output logic              sample_tick
);
  localparam int unsigned BCW = (SLOW_CYC > 1) ? $clog2(SLOW_CYC) : 1;

  logic [BCW-1:0]   bcnt;
  logic [BCW-1:0]   blim;
  logic [DIV_W-1:0] dcnt;
  logic             base_tick;

  assign blim        = (code == '0) ? BCW'(FAST_CYC - 1) : BCW'(SLOW_CYC - 1);
  assign base_tick   = (bcnt == blim);
  assign sample_tick = base_tick && (dcnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      bcnt <= '0;
      dcnt <= '0;
    end else if (base_tick) begin
      bcnt <= '0;
      dcnt <= (dcnt == div) ? '0 : dcnt + 1'b1;
    end else begin
      bcnt <= bcnt + 1'b1;
    end
  end

  // R3
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sample_tick);
  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !restart) |=> !sample_tick);
endmodule

// File: rtl/sti_status.sv
module sti_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic pll_locked,
  input  logic status_rd,
  output logic raw_flag,
  output logic clk_flag,
  output logic clk_evt
);
  logic pll_q;

  assign clk_evt = pll_locked && !pll_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_q    <= 1'b0;
      raw_flag <= 1'b0;
      clk_flag <= 1'b0;
    end else begin
      pll_q    <= pll_locked;
      raw_flag <= sample_tick || (raw_flag && !status_rd);
      clk_flag <= clk_evt || (clk_flag && !status_rd);
    end
  end

  // R5
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_flag && !status_rd) |=> raw_flag);
  // R5
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !sample_tick) |=> !raw_flag);
endmodule

// File: rtl/sti_irq.sv
module sti_irq
  import sti_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 12500
) (
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cfg_t cfg,
  input  logic     raw_evt,
  input  logic     clk_evt,
  input  logic     any_rd,
  input  logic     status_rd,
  output logic     int_pin,
  output logic     int_oe
);
  localparam int unsigned PCW = $clog2(PULSE_CYC + 1);

  logic           evt;
  logic           clr;
  logic           latched_q;
  logic [PCW-1:0] pcnt;
  logic           active;

  assign evt    = (raw_evt && cfg.raw_en) || (clk_evt && cfg.clk_en);
  assign clr    = cfg.any_rd_clr ? any_rd : status_rd;
  assign active = latched_q || (pcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      pcnt      <= '0;
    end else begin
      latched_q <= cfg.latch && (evt || (latched_q && !clr));
      if (evt && !cfg.latch)
        pcnt <= PCW'(PULSE_CYC);
      else if (pcnt != '0)
        pcnt <= pcnt - 1'b1;
    end
  end

  assign int_pin = active ^ cfg.act_low;
  assign int_oe  = cfg.open_drain ? active : 1'b1;

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && cfg.latch && !clr) |=> latched_q);
  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !cfg.latch) |=> active);
  // R10
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.open_drain && !active) |-> !int_oe);
endmodule

// File: rtl/sens_tick_irq.sv
module sens_tick_irq
  import sti_pkg::*;
#(
  parameter int unsigned FAST_CYC  = 31250,
  parameter int unsigned SLOW_CYC  = 250000,
  parameter int unsigned PULSE_CYC = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       pll_locked,
  output logic       int_pin,
  output logic       int_oe
);
  logic [DIV_W-1:0]  div_q;
  logic [CODE_W-1:0] code_q;
  irq_cfg_t          cfg_q;
  logic              restart;
  logic              status_rd;
  logic              sample_tick;
  logic              raw_flag;
  logic              clk_flag;
  logic              clk_evt;
  logic [7:0]        status;

  assign status = {5'b0, clk_flag, 1'b0, raw_flag};

  sti_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status),
    .reg_rdata(reg_rdata), .div_q(div_q), .code_q(code_q), .cfg_q(cfg_q),
    .restart(restart), .status_rd(status_rd)
  );

  sti_tick #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .code(code_q),
    .div(div_q), .sample_tick(sample_tick)
  );

  sti_status u_status (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .pll_locked(pll_locked), .status_rd(status_rd),
    .raw_flag(raw_flag), .clk_flag(clk_flag), .clk_evt(clk_evt)
  );

  sti_irq #(.PULSE_CYC(PULSE_CYC)) u_irq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .raw_evt(sample_tick),
    .clk_evt(clk_evt), .any_rd(reg_rd), .status_rd(status_rd),
    .int_pin(int_pin), .int_oe(int_oe)
  );

  // R5
  stat_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STAT) |-> (reg_rdata[7:3] == 5'b0 && reg_rdata[1] == 1'b0));
endmodule

// File: tb/sens_tick_irq_bench.sv
`timescale 1ns/1ps
module sens_tick_irq_bench;
  localparam int FAST = 4;
  localparam int SLOW = 32;
  localparam int PW   = 5;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, pll_locked = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic int_pin, int_oe;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sens_tick_irq #(.FAST_CYC(FAST), .SLOW_CYC(SLOW), .PULSE_CYC(PW)) u_sens_tick_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pll_locked(pll_locked), .int_pin(int_pin), .int_oe(int_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // each task starts at a falling edge and samples 1 ns later
  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int c);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b0; reg_addr = a; reg_wdata = d;
    #1 c = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output int c);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata; c = cyc;
  endtask

  task automatic nop(output int c);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    #1 c = cyc;
  endtask

  task automatic wait_oe(input int bound, output int c);
    int k = 0;
    nop(c);
    while (!int_oe && k < bound) begin nop(c); k++; end
  endtask

  task automatic wait_pin(input logic lvl, input int bound, output int c);
    int k = 0;
    nop(c);
    while (int_pin !== lvl && k < bound) begin nop(c); k++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    int c, c0, c1, c2, first, len, p;
    int codes[3] = '{0, 3, 6};
    int divs[4]  = '{0, 2, 5, 255};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R4
    rd(2'd3, d, c); chk("R4 status reset", d, 0);
    rd(2'd0, d, c); chk("R4 divider reset", d, 0);
    rd(2'd1, d, c); chk("R4 filter reset", d, 0);
    rd(2'd2, d, c); chk("R4 config reset", d, 0);
    nop(c); chk("R9 pin idle after reset", int_pin, 0);
    chk("R10 oe after reset", int_oe, 1);

    wr(2'd2, 8'hFF, c); rd(2'd2, d, c); chk("R4 config reserved bits", d, 8'hF5);
    wr(2'd2, 8'h00, c);
    wr(2'd1, 8'd5, c); rd(2'd1, d, c); chk("R4 filter readback", d, 5);

    // R1 R2 R3 sweep of filter codes and divider values
    foreach (codes[i]) begin
      foreach (divs[j]) begin
        p = ((codes[i] == 0) ? FAST : SLOW) * (divs[j] + 1);
        wr(2'd1, 8'(codes[i]), c);
        wr(2'd0, 8'(divs[j]), c);
        rd(2'd3, d, c0);           // restart edge count; stale flags drop here
        c1 = -1; c2 = -1;
        for (int k = 0; k < 2 * p + 8; k++) begin
          rd(2'd3, d, c);
          if (d[0]) begin
            if (c1 < 0) c1 = c; else if (c2 < 0) c2 = c;
          end
          if (c2 >= 0) break;
        end
        chk($sformatf("R3 first tick code%0d div%0d", codes[i], divs[j]), c1 - c0, p);
        chk($sformatf("R2 tick period code%0d div%0d", codes[i], divs[j]), c2 - c1, p);
      end
    end

    // R8 pulse mode, period 16 > pulse width
    wr(2'd2, 8'h00, c);
    wr(2'd1, 8'd0, c);
    wr(2'd0, 8'd3, c);
    wr(2'd2, 8'h01, c0);
    first = -1; len = 0;
    for (int k = 0; k < 40; k++) begin
      nop(c);
      if (int_pin) begin
        if (first < 0) first = c;
        len++;
      end else if (first >= 0) break;
    end
    chk("R8 pulse start cycle", first - c0, 16);
    chk("R8 pulse width", len, PW);
    // retrigger: period 4 < pulse width keeps pin active
    wr(2'd0, 8'd0, c);
    wait_pin(1'b1, 20, c);
    len = 0;
    for (int k = 0; k < 40; k++) begin nop(c); if (int_pin) len++; end
    chk("R8 retrigger holds pulse", len, 40);

    // R7 latched, status-only clear
    wr(2'd2, 8'h00, c);
    wr(2'd0, 8'd7, c);               // period 32
    repeat (PW + 1) nop(c);
    wr(2'd2, 8'h21, c);
    wait_pin(1'b1, 80, c);
    chk("R7 latch asserts", int_pin, 1);
    rd(2'd0, d, c);
    nop(c); chk("R7 non-status read keeps latch", int_pin, 1);
    rd(2'd3, d, c); chk("R5 status read sees raw ready", d[0], 1);
    nop(c); chk("R7 status read clears latch", int_pin, 0);
    // R7 any-read clear
    wr(2'd2, 8'h31, c);
    wait_pin(1'b1, 80, c);
    rd(2'd1, d, c);
    nop(c); chk("R7 any read clears latch", int_pin, 0);

    // R6 enables off: no interrupt, flag still sets
    wr(2'd2, 8'h20, c);
    rd(2'd3, d, c);
    len = 0;
    for (int k = 0; k < 80; k++) begin nop(c); if (int_pin) len++; end
    chk("R6 raw disabled no interrupt", len, 0);
    rd(2'd3, d, c); chk("R6 raw flag sets while disabled", d[0], 1);
    @(negedge clk); pll_locked = 1'b1; reg_rd = 1'b0;
    rd(2'd3, d, c); chk("R5 clock ready on lock rise", d[2], 1);
    chk("R6 clock disabled no interrupt", int_pin, 0);
    rd(2'd3, d, c); chk("R5 status clears after read", d[2], 0);
    // clock-ready enabled
    wr(2'd2, 8'h24, c);
    @(negedge clk); pll_locked = 1'b0; reg_wr = 1'b0;
    @(negedge clk); pll_locked = 1'b1;
    nop(c); chk("R6 clock ready raises interrupt", int_pin, 1);
    rd(2'd3, d, c); chk("R5 clock flag before clear", d[2], 1);
    nop(c); chk("R7 clock interrupt cleared", int_pin, 0);

    // R9 R10 polarity and drive
    wr(2'd2, 8'h80, c);
    nop(c); chk("R9 active-low idle level", int_pin, 1);
    chk("R10 push-pull drives", int_oe, 1);
    wr(2'd2, 8'hC0, c);
    nop(c); chk("R10 open drain released", int_oe, 0);
    wr(2'd2, 8'hE1, c);
    wait_oe(80, c);
    chk("R10 open drain drives when active", int_oe, 1);
    chk("R9 active-low asserted level", int_pin, 0);
    rd(2'd3, d, c);
    nop(c); chk("R10 open drain releases after clear", int_oe, 0);
    wr(2'd2, 8'h61, c);
    wait_oe(80, c);
    chk("R9 active-high asserted level", int_pin, 1);

    finish_run();
  end
endmodule